// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

The block watches the recovered mark/space stream of one receive line. It raises a digital loss-of-signal flag once a programmable number of consecutive zero bits has been seen. It drops that flag only after the line shows enough pulse density again. The density is judged over back-to-back blocks of a fixed number of bit periods. A block passes when three times its mark count exceeds the block length, so the block needs no divider.

The digital flag is ORed with an analog loss-of-signal flag from the analog front end to form the receive loss-of-signal output. In the high-order line mode, the analog flag counts only after it has held for a fixed number of bit periods. Each detector has its own disable input for debug. Two sticky status bits record that a condition was seen, and a write-one-to-clear input clears them.

Top module: `line_los_monitor`

## Requirements
- R1: With `zero_thr_i` inside [THR_MIN, THR_MAX], `dlos_o` rises on the clock edge that takes in the `zero_thr_i`-th consecutive zero strobe, meaning a strobe with `mark_i`=0. A mark strobe restarts the zero run.
- R2: A `zero_thr_i` value below THR_MIN acts as THR_MIN. A value above THR_MAX acts as THR_MAX.
- R3: `mark_i` has no effect in a cycle where `bit_en_i` is 0. Without a strobe, `dlos_o` does not change.
- R4: While `dlos_o` is 1, strobes are grouped into consecutive blocks of WIN strobes. The first block starts with the first strobe after the declaration. `dlos_o` falls on the edge that takes in the last strobe of a block whose mark count m satisfies 3*m > WIN. Otherwise it stays 1 and a new block begins.
- R5: With `e3_mode_i`=0, `rlos_o` equals `dlos_o` OR (`alos_i` AND NOT `alos_dis_i`), combinationally.
- R6: With `e3_mode_i`=1, the analog flag contributes to `rlos_o` only once `alos_i` has stayed 1 across PERSIST strobes. The contribution is visible after the edge of the PERSIST-th strobe. It is withdrawn as soon as `alos_i` goes to 0.
- R7: While `dlos_dis_i` is 1, the detector is held in the clear state. `dlos_o` is 0 one edge later and no zero run accumulates.
- R8: While `alos_dis_i` is 1, `alos_i` does not contribute to `rlos_o` in either mode.
- R9: `dlos_st_o` and `rlos_st_o` are set one edge after `dlos_o` or `rlos_o`, respectively, is 1. They stay set until a pulse on `st_clr_i` clears them: bit 0 clears `dlos_st_o` and bit 1 clears `rlos_st_o`. A live condition wins over the clear.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe per received bit |
| mark_i | input | 1 | 1 when the strobed bit is a mark |
| zero_thr_i | input | CW | Zero-run declaration threshold |
| alos_i | input | 1 | Analog loss-of-signal flag |
| e3_mode_i | input | 1 | Apply persistence qualification to `alos_i` |
| dlos_dis_i | input | 1 | Disable the digital detector |
| alos_dis_i | input | 1 | Mask the analog flag |
| st_clr_i | input | 2 | Write-one-to-clear for the status bits |
| dlos_o | output | 1 | Live digital loss-of-signal |
| rlos_o | output | 1 | Live receive loss-of-signal |
| dlos_st_o | output | 1 | Sticky digital status |
| rlos_st_o | output | 1 | Sticky receive status |

## Verification
The bench builds the block with CW=5, THR_MIN=4, THR_MAX=20, WIN=12 and PERSIST=6. These values bring both clamp limits, a full recovery block and the persistence window within a few dozen strobes. The small WIN also puts the density boundary at four marks (fail) against five marks (pass), and both sides are driven. The threshold is moved across and beyond both clamp limits to reach R2.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    LOS_OK  = 1'b0,
    LOS_ACT = 1'b1
  } los_state_e;
endpackage

// File: rtl/zero_run_ctr.sv
module zero_run_ctr #(
  parameter int CW      = 8,
  parameter int THR_MIN = 100,
  parameter int THR_MAX = 250
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          strobe_i,
  input  logic          mark_i,
  input  logic [CW-1:0] thr_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] MINV = CW'(THR_MIN);
  localparam logic [CW-1:0] MAXV = CW'(THR_MAX);

  logic [CW-1:0] thr_eff;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;

  always_comb begin
    if (thr_i < MINV)      thr_eff = MINV;
    else if (thr_i > MAXV) thr_eff = MAXV;
    else                   thr_eff = thr_i;
  end

  assign cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i)              cnt_q <= '0;
    else if (strobe_i) begin
      if (mark_i)                cnt_q <= '0;
      else if (cnt_q < thr_eff)  cnt_q <= cnt_q + CW'(1);
      else                       cnt_q <= thr_eff; // saturate
    end
  end

  assign hit_o = en_i & strobe_i & ~mark_i & (cnt_inc >= {1'b0, thr_eff});
endmodule

// File: rtl/density_win.sv
module density_win #(
  parameter int WIN = 175
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic strobe_i,
  input  logic mark_i,
  output logic pass_o
);
  localparam int BW = $clog2(WIN + 1);

  logic [BW-1:0] pos_q;
  logic [BW-1:0] marks_q;
  logic [BW:0]   m_tot;
  logic [BW+2:0] m3;
  logic          last;

  assign last  = (pos_q == BW'(WIN - 1));
  assign m_tot = {1'b0, marks_q} + (BW+1)'(mark_i);
  assign m3    = ({2'b0, m_tot} << 1) + {2'b0, m_tot};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      marks_q <= '0;
    end else if (!active_i) begin
      pos_q   <= '0;
      marks_q <= '0;
    end else if (strobe_i) begin
      if (last) begin
        pos_q   <= '0;
        marks_q <= '0;
      end else begin
        pos_q   <= pos_q + BW'(1);
        marks_q <= m_tot[BW-1:0];
      end
    end
  end

  // density > 1/3 without a divider
  assign pass_o = active_i & strobe_i & last & (m3 > (BW+3)'(WIN));
endmodule

// File: rtl/alos_qual.sv
module alos_qual #(
  parameter int PERSIST = 175
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alos_i,
  input  logic dis_i,
  input  logic e3_i,
  input  logic strobe_i,
  output logic alos_eff_o
);
  localparam int PW = $clog2(PERSIST + 1);

  logic [PW-1:0] cnt_q;
  logic          full;

  assign full = (cnt_q == PW'(PERSIST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (dis_i || !alos_i || !e3_i) cnt_q <= '0;
    else if (strobe_i && !full)         cnt_q <= cnt_q + PW'(1);
  end

  assign alos_eff_o = ~dis_i & alos_i & (~e3_i | full);
endmodule

// File: rtl/line_los_monitor.sv
module line_los_monitor #(
  parameter int CW      = 8,
  parameter int THR_MIN = 100,
  parameter int THR_MAX = 250,
  parameter int WIN     = 175,
  parameter int PERSIST = 175
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          mark_i,
  input  logic [CW-1:0] zero_thr_i,
  input  logic          alos_i,
  input  logic          e3_mode_i,
  input  logic          dlos_dis_i,
  input  logic          alos_dis_i,
  input  logic [1:0]    st_clr_i,
  output logic          dlos_o,
  output logic          rlos_o,
  output logic          dlos_st_o,
  output logic          rlos_st_o
);
  import los_pkg::*;

  los_state_e state_q, state_d;
  logic       det_en;
  logic       run_hit;
  logic       win_pass;
  logic       alos_eff;
  logic       dst_q, rst_q;

  assign det_en = ~dlos_dis_i;

  zero_run_ctr #(.CW(CW), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX)) u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (det_en),
    .strobe_i (bit_en_i),
    .mark_i   (mark_i),
    .thr_i    (zero_thr_i),
    .hit_o    (run_hit)
  );

  density_win #(.WIN(WIN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (det_en & (state_q == LOS_ACT)),
    .strobe_i (bit_en_i),
    .mark_i   (mark_i),
    .pass_o   (win_pass)
  );

  alos_qual #(.PERSIST(PERSIST)) u_alos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alos_i     (alos_i),
    .dis_i      (alos_dis_i),
    .e3_i       (e3_mode_i),
    .strobe_i   (bit_en_i),
    .alos_eff_o (alos_eff)
  );

  always_comb begin
    state_d = state_q;
    if (!det_en)                                 state_d = LOS_OK;
    else if (state_q == LOS_OK  && run_hit)      state_d = LOS_ACT;
    else if (state_q == LOS_ACT && win_pass)     state_d = LOS_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LOS_OK;
    else         state_q <= state_d;
  end

  assign dlos_o = (state_q == LOS_ACT);
  assign rlos_o = dlos_o | alos_eff;

  // live condition has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      dst_q <= dlos_o | (dst_q & ~st_clr_i[0]);
      rst_q <= rlos_o | (rst_q & ~st_clr_i[1]);
    end
  end

  assign dlos_st_o = dst_q;
  assign rlos_st_o = rst_q;
endmodule

// File: rtl/los_chk.sv
module los_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       mark_i,
  input logic       alos_i,
  input logic       e3_mode_i,
  input logic       dlos_dis_i,
  input logic       alos_dis_i,
  input logic [1:0] st_clr_i,
  input logic       dlos_o,
  input logic       rlos_o,
  input logic       dlos_st_o,
  input logic       rlos_st_o
);
  AST_MARK_NO_DECL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && mark_i && !dlos_o) |=> !dlos_o); // R1
  AST_NO_STROBE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !dlos_dis_i) |=> $stable(dlos_o)); // R3
  AST_RLOS_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !e3_mode_i |-> (rlos_o == (dlos_o || (alos_i && !alos_dis_i)))); // R5
  AST_DLOS_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlos_dis_i |=> !dlos_o); // R7
  AST_ALOS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alos_dis_i && !dlos_o) |-> !rlos_o); // R8
  AST_DST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlos_o |=> dlos_st_o); // R9
  AST_RST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rlos_o |=> rlos_st_o); // R9
  AST_DST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlos_st_o && !st_clr_i[0]) |=> dlos_st_o); // R9
  AST_RST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rlos_st_o && !st_clr_i[1]) |=> rlos_st_o); // R9
endmodule

bind line_los_monitor los_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .mark_i     (mark_i),
  .alos_i     (alos_i),
  .e3_mode_i  (e3_mode_i),
  .dlos_dis_i (dlos_dis_i),
  .alos_dis_i (alos_dis_i),
  .st_clr_i   (st_clr_i),
  .dlos_o     (dlos_o),
  .rlos_o     (rlos_o),
  .dlos_st_o  (dlos_st_o),
  .rlos_st_o  (rlos_st_o)
);

// File: tb/sim_line_los_monitor.sv
module sim_line_los_monitor;
  localparam int CW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bit_en_i = 1'b0;
  logic          mark_i = 1'b0;
  logic [CW-1:0] zero_thr_i = CW'(8);
  logic          alos_i = 1'b0;
  logic          e3_mode_i = 1'b0;
  logic          dlos_dis_i = 1'b0;
  logic          alos_dis_i = 1'b0;
  logic [1:0]    st_clr_i = 2'b00;
  logic          dlos_o, rlos_o, dlos_st_o, rlos_st_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  line_los_monitor #(.CW(CW), .THR_MIN(4), .THR_MAX(20), .WIN(12), .PERSIST(6)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .mark_i(mark_i),
    .zero_thr_i(zero_thr_i), .alos_i(alos_i), .e3_mode_i(e3_mode_i),
    .dlos_dis_i(dlos_dis_i), .alos_dis_i(alos_dis_i), .st_clr_i(st_clr_i),
    .dlos_o(dlos_o), .rlos_o(rlos_o), .dlos_st_o(dlos_st_o), .rlos_st_o(rlos_st_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; bit_en_i = 1'b0; mark_i = 1'b0; alos_i = 1'b0;
    e3_mode_i = 1'b0; dlos_dis_i = 1'b0; alos_dis_i = 1'b0; st_clr_i = 2'b00;
    zero_thr_i = CW'(8);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic send(input int n, input logic m);
    for (int i = 0; i < n; i++) begin
      bit_en_i = 1'b1; mark_i = m;
      @(negedge clk_i);
    end
    bit_en_i = 1'b0; mark_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 dlos", dlos_o, 1'b0);
    check("R10 rlos", rlos_o, 1'b0);
    check("R10 dlos_st", dlos_st_o, 1'b0);
    check("R10 rlos_st", rlos_st_o, 1'b0);
  endtask

  task automatic t_threshold();
    do_reset();
    send(7, 1'b0);
    check("R1 below thr", dlos_o, 1'b0);
    send(1, 1'b0);
    check("R1 at thr", dlos_o, 1'b1);
    do_reset();
    send(7, 1'b0); send(1, 1'b1); send(7, 1'b0);
    check("R1 mark restarts run", dlos_o, 1'b0);
    send(1, 1'b0);
    check("R1 after restart", dlos_o, 1'b1);
  endtask

  task automatic t_clamp();
    do_reset();
    zero_thr_i = CW'(2);
    send(3, 1'b0);
    check("R2 low clamp below", dlos_o, 1'b0);
    send(1, 1'b0);
    check("R2 low clamp at", dlos_o, 1'b1);
    do_reset();
    zero_thr_i = CW'(30);
    send(19, 1'b0);
    check("R2 high clamp below", dlos_o, 1'b0);
    send(1, 1'b0);
    check("R2 high clamp at", dlos_o, 1'b1);
  endtask

  task automatic t_strobe();
    do_reset();
    send(7, 1'b0);
    mark_i = 1'b1;
    repeat (5) @(negedge clk_i);
    mark_i = 1'b0;
    check("R3 no strobe no effect", dlos_o, 1'b0);
    send(1, 1'b0);
    check("R3 run kept across idle", dlos_o, 1'b1);
  endtask

  task automatic blk4();
    for (int k = 0; k < 4; k++) begin send(1, 1'b1); send(2, 1'b0); end
  endtask

  task automatic t_clear();
    do_reset();
    send(8, 1'b0);
    check("R4 declared", dlos_o, 1'b1);
    blk4();
    check("R4 four marks keep los", dlos_o, 1'b1);
    for (int k = 0; k < 3; k++) begin send(1, 1'b1); send(2, 1'b0); end
    send(1, 1'b1); send(1, 1'b0);
    check("R4 mid block", dlos_o, 1'b1);
    send(1, 1'b1);
    check("R4 five marks clear", dlos_o, 1'b0);
  endtask

  task automatic t_rlos();
    do_reset();
    alos_i = 1'b1; #1;
    check("R5 alos to rlos", rlos_o, 1'b1);
    alos_i = 1'b0; #1;
    check("R5 alos low", rlos_o, 1'b0);
    @(negedge clk_i);
    send(8, 1'b0);
    check("R5 dlos to rlos", rlos_o, 1'b1);
  endtask

  task automatic t_e3();
    do_reset();
    e3_mode_i = 1'b1; alos_i = 1'b1;
    repeat (3) @(negedge clk_i);
    send(5, 1'b1);
    check("R6 before persist", rlos_o, 1'b0);
    send(1, 1'b1);
    check("R6 at persist", rlos_o, 1'b1);
    alos_i = 1'b0; #1;
    check("R6 drop", rlos_o, 1'b0);
    @(negedge clk_i);
  endtask

  task automatic t_dlos_dis();
    do_reset();
    dlos_dis_i = 1'b1; zero_thr_i = CW'(4);
    send(30, 1'b0);
    check("R7 disabled dlos", dlos_o, 1'b0);
    check("R7 disabled rlos", rlos_o, 1'b0);
    dlos_dis_i = 1'b0;
    send(3, 1'b0);
    check("R7 no run kept", dlos_o, 1'b0);
    send(1, 1'b0);
    check("R7 declared", dlos_o, 1'b1);
    dlos_dis_i = 1'b1;
    @(negedge clk_i);
    check("R7 forced clear", dlos_o, 1'b0);
  endtask

  task automatic t_alos_dis();
    do_reset();
    alos_dis_i = 1'b1; alos_i = 1'b1; #1;
    check("R8 masked", rlos_o, 1'b0);
    e3_mode_i = 1'b1;
    @(negedge clk_i);
    send(10, 1'b1);
    check("R8 masked e3", rlos_o, 1'b0);
    check("R8 no status", rlos_st_o, 1'b0);
  endtask

  task automatic t_status();
    do_reset();
    send(8, 1'b0);
    @(negedge clk_i);
    check("R9 dlos_st set", dlos_st_o, 1'b1);
    check("R9 rlos_st set", rlos_st_o, 1'b1);
    st_clr_i = 2'b01; @(negedge clk_i); st_clr_i = 2'b00;
    check("R9 live wins", dlos_st_o, 1'b1);
    send(12, 1'b1);
    check("R9 cleared live", dlos_o, 1'b0);
    @(negedge clk_i);
    check("R9 sticky", dlos_st_o, 1'b1);
    st_clr_i = 2'b01; @(negedge clk_i); st_clr_i = 2'b00;
    check("R9 w1c dlos", dlos_st_o, 1'b0);
    check("R9 rlos kept", rlos_st_o, 1'b1);
    st_clr_i = 2'b10; @(negedge clk_i); st_clr_i = 2'b00;
    check("R9 w1c rlos", rlos_st_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_threshold();
    t_clamp();
    t_strobe();
    t_clear();
    t_rlos();
    t_e3();
    t_dlos_dis();
    t_alos_dis();
    t_status();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule